// File: doc/BRIEF.md
# Transceiver Configuration Register Bank

This block keeps five 8-bit control registers for a mixed-signal transceiver. A host writes and reads them through a simple parallel register port: one write strobe, an address and write data, with read data that follows the address combinationally. From the stored values the block drives the lines that downstream logic uses. These are the power-down enables for each analog or digital function, the serial bit-order select, and decoded clock-generator settings: the main PLL multiplier, the secondary PLL M and N codes, the ADC clock source and the transmit sampling edge.

Register 0 implements two bits. Bit 6 selects least-significant-bit-first shifting for the serial port. Bit 5 requests a software reset, which lasts one cycle and then clears itself. The software reset returns every register to zero but leaves the bit-order flag as it was. Registers 1 and 2 are two power-down masks, and the external `pwr_sel` pin chooses between them at any time. Register 3 carries the clock configuration. Register 4 carries the receive filter controls.

Top module: `cfg_bank`

## Requirements
- R1: After hardware reset (`rst_n` low), every register reads 0, `pd_en` is 0, `lsb_first` is 0 and `soft_rst_pulse` is 0.
- R2: Registers 1 to 4 store all 8 written bits and read them back. Register 0 reads back only bit 6 (bit order) and bit 5 (reset request); its other bits read 0. Addresses 5 to 7 read 0 and ignore writes.
- R3: A write to register 0 with bit 5 set raises `soft_rst_pulse` in the cycle that follows the write edge. The pulse lasts exactly one cycle. During that cycle register 0 reads with bit 5 set, and afterwards bit 5 reads 0.
- R4: At the end of the software reset cycle, registers 1 to 4 and register 0 bit 5 are 0.
- R5: Register 0 bit 6 keeps its value through a software reset. A hardware reset clears it.
- R6: `lsb_first` equals register 0 bit 6 (1 = least significant bit first, 0 = most significant bit first).
- R7: `pd_en` follows register 1 while `pwr_sel` is 0 and register 2 while `pwr_sel` is 1, with no clock delay after the pin changes.
- R8: When register 4 bit 0 (receive filter bypass, also output on `rx_lpf_bypass`) is 1, `pd_en[0]` is 1 whatever the selected mask holds. Register 4 bit 1 drives `rx_one_pole_en`.
- R9: `plla_mult` is the main PLL factor selected by register 3 bits 1:0: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R10: `pllb_m` decodes register 3 bits 5:4 as 0→3, 1→4, 2→6 and 3→3. `pllb_n` decodes register 3 bits 3:2 as 0→2, 1→4, 2→1 and 3→2.
- R11: `tx_fall_edge` equals register 3 bit 7 (1 = sample on the falling edge). `adc_clk_div` equals register 3 bit 6.
- R12: A write presented during the software reset cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pwr_sel | input | 1 | Selects power-down mask: 0 register 1, 1 register 2 |
| pd_en | output | 8 | Power-down enables (bit 0 rx filter/coarse gain ... bit 7 regulator) |
| soft_rst_pulse | output | 1 | One-cycle software reset pulse |
| lsb_first | output | 1 | Serial bit order, 1 = LSB first |
| plla_mult | output | 4 | Main PLL multiplication factor |
| pllb_m | output | 3 | Secondary PLL multiplier M |
| pllb_n | output | 3 | Secondary PLL divider N |
| adc_clk_div | output | 1 | ADC clock taken from the secondary PLL divided by two |
| tx_fall_edge | output | 1 | Transmit port samples on the falling edge |
| rx_lpf_bypass | output | 1 | Receive filter bypass |
| rx_one_pole_en | output | 1 | Extra single-pole receive filter enable |

## Verification
A register write lands on the rising edge that captures the strobe. Its stored value, the read data and every decoded output are therefore valid one cycle after the strobe is presented. The bench drives each write on a falling edge and checks at the next falling edge. `pd_en` and `rdata` are combinational from `pwr_sel` and `addr`, so the bench checks them one time unit after it changes the pin or the address. The software reset pulse is visible in the cycle after the write. The cleared registers are due one cycle later still, so the bench checks the pulse and the read-back of bit 5 at the first falling edge and the cleared state at the second.

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          pwr_sel,
  output logic [DW-1:0] pd_en,
  output logic          soft_rst_pulse,
  output logic          lsb_first,
  output logic [3:0]    plla_mult,
  output logic [2:0]    pllb_m,
  output logic [2:0]    pllb_n,
  output logic          adc_clk_div,
  output logic          tx_fall_edge,
  output logic          rx_lpf_bypass,
  output logic          rx_one_pole_en
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PDL  = AW'(1);
  localparam logic [AW-1:0] A_PDH  = AW'(2);
  localparam logic [AW-1:0] A_CLK  = AW'(3);
  localparam logic [AW-1:0] A_FILT = AW'(4);
  localparam int B_SRST  = 5;
  localparam int B_ORDER = 6;

  logic          soft_q, order_q;
  logic [DW-1:0] pd_lo, pd_hi, clk_cfg, filt_cfg;
  logic [DW-1:0] ctrl_rd, mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_q   <= 1'b0;
      order_q  <= 1'b0;
      pd_lo    <= '0;
      pd_hi    <= '0;
      clk_cfg  <= '0;
      filt_cfg <= '0;
    end else if (soft_q) begin
      soft_q   <= 1'b0;
      pd_lo    <= '0;
      pd_hi    <= '0;
      clk_cfg  <= '0;
      filt_cfg <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          order_q <= wdata[B_ORDER];
          soft_q  <= wdata[B_SRST];
        end
        A_PDL:  pd_lo    <= wdata;
        A_PDH:  pd_hi    <= wdata;
        A_CLK:  clk_cfg  <= wdata;
        A_FILT: filt_cfg <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[B_SRST]  = soft_q;
    ctrl_rd[B_ORDER] = order_q;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_rd;
      A_PDL:   rdata = pd_lo;
      A_PDH:   rdata = pd_hi;
      A_CLK:   rdata = clk_cfg;
      A_FILT:  rdata = filt_cfg;
      default: rdata = '0;
    endcase
  end

  assign mask  = pwr_sel ? pd_hi : pd_lo;
  assign pd_en = {mask[DW-1:1], mask[0] | filt_cfg[0]};

  assign soft_rst_pulse = soft_q;
  assign lsb_first      = order_q;
  assign plla_mult      = 4'b0001 << clk_cfg[1:0];
  assign adc_clk_div    = clk_cfg[6];
  assign tx_fall_edge   = clk_cfg[7];
  assign rx_lpf_bypass  = filt_cfg[0];
  assign rx_one_pole_en = filt_cfg[1];

  always_comb begin
    case (clk_cfg[5:4])
      2'b01:   pllb_m = 3'd4;
      2'b10:   pllb_m = 3'd6;
      default: pllb_m = 3'd3;
    endcase
    case (clk_cfg[3:2])
      2'b01:   pllb_n = 3'd4;
      2'b10:   pllb_n = 3'd1;
      default: pllb_n = 3'd2;
    endcase
  end

  // R3
  soft_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL && wdata[B_SRST] && !soft_rst_pulse) |=> soft_rst_pulse);
  // R3
  soft_one_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !soft_rst_pulse);
  // R4
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> (pd_lo == '0 && pd_hi == '0 && clk_cfg == '0 && filt_cfg == '0));
  // R5
  order_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> lsb_first == $past(lsb_first));
  // R8
  bypass_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lpf_bypass |-> pd_en[0]);
endmodule

// File: tb/tb_cfg_bank.sv
module tb_cfg_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       pwr_sel = 1'b0;
  logic [7:0] rdata, pd_en;
  logic       soft_rst_pulse, lsb_first, adc_clk_div, tx_fall_edge;
  logic       rx_lpf_bypass, rx_one_pole_en;
  logic [3:0] plla_mult;
  logic [2:0] pllb_m, pllb_n;
  int checks = 0, fails = 0, cycles = 0;

  cfg_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwr_sel(pwr_sel), .pd_en(pd_en),
    .soft_rst_pulse(soft_rst_pulse), .lsb_first(lsb_first),
    .plla_mult(plla_mult), .pllb_m(pllb_m), .pllb_n(pllb_n),
    .adc_clk_div(adc_clk_div), .tx_fall_edge(tx_fall_edge),
    .rx_lpf_bypass(rx_lpf_bypass), .rx_one_pole_en(rx_one_pole_en)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_up();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  function automatic logic [2:0] exp_m(input int c);
    return (c == 1) ? 3'd4 : (c == 2) ? 3'd6 : 3'd3;
  endfunction
  function automatic logic [2:0] exp_n(input int c);
    return (c == 1) ? 3'd4 : (c == 2) ? 3'd1 : 3'd2;
  endfunction

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd_chk("R1 reg", 3'(a), 8'h00);
    chk("R1 pd_en", pd_en, 8'h00);
    chk("R1 lsb_first", {7'b0, lsb_first}, 8'h00);
    chk("R1 soft_rst_pulse", {7'b0, soft_rst_pulse}, 8'h00);
  endtask

  task automatic t_rw();
    wr(3'd1, 8'h5A); wr(3'd2, 8'hC3); wr(3'd3, 8'h0F); wr(3'd4, 8'h02);
    wr(3'd0, 8'h9F); wr(3'd5, 8'hFF); wr(3'd7, 8'h11);
    rd_chk("R2 reg1", 3'd1, 8'h5A);
    rd_chk("R2 reg2", 3'd2, 8'hC3);
    rd_chk("R2 reg3", 3'd3, 8'h0F);
    rd_chk("R2 reg4", 3'd4, 8'h02);
    rd_chk("R2 reg0 masked", 3'd0, 8'h00);
    rd_chk("R2 addr5", 3'd5, 8'h00);
    rd_chk("R2 addr7", 3'd7, 8'h00);
    chk("R8 one pole", {7'b0, rx_one_pole_en}, 8'h01);
  endtask

  task automatic t_order();
    wr(3'd0, 8'h40);
    chk("R6 lsb first", {7'b0, lsb_first}, 8'h01);
    rd_chk("R6 reg0", 3'd0, 8'h40);
    wr(3'd0, 8'h00);
    chk("R6 msb first", {7'b0, lsb_first}, 8'h00);
  endtask

  task automatic t_soft();
    wr(3'd1, 8'hFF); wr(3'd3, 8'hAA);
    wr(3'd0, 8'h60);
    chk("R3 pulse high", {7'b0, soft_rst_pulse}, 8'h01);
    rd_chk("R3 reg0 during pulse", 3'd0, 8'h60);
    wr_en = 1'b1; addr = 3'd2; wdata = 8'h77;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R3 pulse one cycle", {7'b0, soft_rst_pulse}, 8'h00);
    rd_chk("R3 reg0 bit5 cleared", 3'd0, 8'h40);
    rd_chk("R4 reg1 cleared", 3'd1, 8'h00);
    rd_chk("R4 reg3 cleared", 3'd3, 8'h00);
    rd_chk("R12 write discarded", 3'd2, 8'h00);
    chk("R5 order kept", {7'b0, lsb_first}, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R5 hw reset clears order", {7'b0, lsb_first}, 8'h00);
  endtask

  task automatic t_power();
    wr(3'd1, 8'hA4); wr(3'd2, 8'h3C); wr(3'd4, 8'h00);
    pwr_sel = 1'b0; #1;
    chk("R7 sel low", pd_en, 8'hA4);
    pwr_sel = 1'b1; #1;
    chk("R7 sel high", pd_en, 8'h3C);
    wr(3'd4, 8'h01);
    chk("R8 bypass out", {7'b0, rx_lpf_bypass}, 8'h01);
    chk("R8 forced high mask", pd_en, 8'h3D);
    pwr_sel = 1'b0; #1;
    chk("R8 forced low mask", pd_en, 8'hA5);
    wr(3'd4, 8'h00);
    chk("R8 released", pd_en, 8'hA4);
  endtask

  task automatic t_clk();
    for (int c = 0; c < 4; c++) begin
      wr(3'd3, 8'(c));
      chk("R9 plla", {4'b0, plla_mult}, 8'(1 << c));
    end
    for (int m = 0; m < 4; m++)
      for (int n = 0; n < 4; n++) begin
        wr(3'd3, 8'((m << 4) | (n << 2)));
        chk("R10 m", {5'b0, pllb_m}, {5'b0, exp_m(m)});
        chk("R10 n", {5'b0, pllb_n}, {5'b0, exp_n(n)});
      end
    wr(3'd3, 8'h80);
    chk("R11 tx fall", {7'b0, tx_fall_edge}, 8'h01);
    chk("R11 adc sel off", {7'b0, adc_clk_div}, 8'h00);
    wr(3'd3, 8'h40);
    chk("R11 tx rise", {7'b0, tx_fall_edge}, 8'h00);
    chk("R11 adc sel on", {7'b0, adc_clk_div}, 8'h01);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rw();
    t_order();
    t_soft();
    t_power();
    t_clk();
    finish_up();
  end
endmodule